// File: doc/BRIEF.md
# Leveled Interrupt Pending and Priority Resolver

This block records interrupt requests from many sources, grouped by priority level. Each level owns a 64-bit pending mask. A one-bit-per-level status vector shows which levels still hold at least one pending source. Sources are posted or cleared one bit at a time through two independent request ports. A single clear-all input wipes the whole store in one cycle.

From the registered status and a software request vector, a combinational resolver builds a summary vector and a candidate priority. Software bits 1 to 15 give priorities 1 to 15, and the highest one wins. Pending levels 16 to 31 override any software candidate, with the highest level winning. Delivery is offered only when some level is pending, the two low program-counter bits are zero, no asynchronous trap request is raised, and the candidate is above the current priority level. When delivery is offered and the update strobe is high, the summary and candidate are latched into the registered summary and ID outputs. Asynchronous trap requests are not serviced; they only raise an error flag.

Top module: `irq_level_resolver`

## Requirements
- R1: A post to level L (below 32) and index I (below 64) sets that source bit. The level counts as pending from the next cycle, so `irq_pending` rises one cycle after the post when `pc_lo` is 0.
- R2: A clear removes only the addressed source bit. A level stays pending while any of its 64 bits remains set, and stops being pending the cycle after its last bit is cleared.
- R3: `clr_all` empties every level in one cycle. It wins over a post or clear given in the same cycle.
- R4: When a post and a clear name the same level and index in the same cycle, the bit ends up set.
- R5: A post or clear whose level field has bit 5 set (level 32 or more) or whose index field has bit 6 set (index 64 or more) changes no pending state. It raises `req_err` for exactly the following cycle.
- R6: `irq_pending` is high exactly when at least one level is pending and `pc_lo` equals 2'b00.
- R7: For each set bit i of `sw_req` with 1 ≤ i ≤ 15, summary bit i is set. The software candidate is the largest such i. Bits 0 and 16 to 31 of `sw_req` have no effect.
- R8: For each pending level L with 16 ≤ L ≤ 31, summary bit L is set. The highest such L becomes the candidate and overrides any software candidate. Pending levels 0 to 15 count only toward R6.
- R9: `irq_take` is high exactly when `irq_pending` is high, the candidate is nonzero and strictly greater than `cur_ipl`, and `ast_req` is zero.
- R10: When `upd_strobe` and `irq_take` are both high at a clock edge, `isr_out` takes the summary and `int_id` takes the candidate. At any other edge both hold their value. Both reset to zero.
- R11: A nonzero `ast_req` sets `trap_err` in the following cycle and holds `irq_take` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request valid |
| post_lvl | input | 6 | Post level; bit 5 set means out of range |
| post_idx | input | 7 | Post source index; bit 6 set means out of range |
| clr_vld | input | 1 | Clear request valid |
| clr_lvl | input | 6 | Clear level; bit 5 set means out of range |
| clr_idx | input | 7 | Clear source index; bit 6 set means out of range |
| clr_all | input | 1 | Empty all levels |
| sw_req | input | 32 | Software interrupt request bits |
| cur_ipl | input | 5 | Current processor priority level |
| pc_lo | input | 2 | Two low program-counter bits |
| ast_req | input | 4 | Asynchronous trap request bits |
| upd_strobe | input | 1 | Latch summary and ID when delivery is offered |
| irq_pending | output | 1 | Some level pending and program counter aligned |
| irq_take | output | 1 | Interrupt delivery offered |
| isr_out | output | 32 | Registered interrupt summary |
| int_id | output | 5 | Registered chosen priority |
| req_err | output | 1 | Out-of-range post or clear seen last cycle |
| trap_err | output | 1 | Asynchronous trap request seen last cycle |

## Verification
The hardest case to reach is a software-derived delivery. Delivery needs some level pending, but any pending level from 16 upward overrides the software candidate. The stimulus therefore posts a single source at level 3, which the resolver counts as pending but never as a candidate. A vector table then sweeps `sw_req`, `cur_ipl`, `pc_lo` and `ast_req` over that state. Directed sequences then cover external override, one-bit clears, post/clear collisions, clear-all precedence and out-of-range requests, all observed through `irq_pending`, `irq_take` and the latched outputs.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int LVL_W      = 5;
  localparam int IDX_W      = 6;
  localparam int NUM_LEVELS = 1 << LVL_W;
  localparam int SRC_N      = 1 << IDX_W;
  localparam int AST_W      = 4;

  // Request fields carry one extra top bit that marks an out-of-range value.
  typedef struct packed {
    logic             vld;
    logic [LVL_W:0]   lvl;
    logic [IDX_W:0]   idx;
  } src_req_t;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_res_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  src_req_t              post_req,
  input  src_req_t              clr_req,
  input  logic                  clr_all,
  output logic [NUM_LEVELS-1:0] status_q,
  output logic                  req_err_q
);
  logic post_ok, clr_ok, post_bad, clr_bad;

  assign post_ok  = post_req.vld && !post_req.lvl[LVL_W] && !post_req.idx[IDX_W];
  assign clr_ok   = clr_req.vld  && !clr_req.lvl[LVL_W]  && !clr_req.idx[IDX_W];
  assign post_bad = post_req.vld && !post_ok;
  assign clr_bad  = clr_req.vld  && !clr_ok;

  always_ff @(posedge clk) begin
    if (rst) req_err_q <= 1'b0;
    else     req_err_q <= post_bad || clr_bad;
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    logic [SRC_N-1:0] mask_q, mask_d, set_v, clr_v;
    logic             lvl_stat_q, post_hit, clr_hit;

    assign post_hit = post_ok && (post_req.lvl[LVL_W-1:0] == LVL_W'(g));
    assign clr_hit  = clr_ok  && (clr_req.lvl[LVL_W-1:0]  == LVL_W'(g));

    always_comb begin
      set_v = '0;
      clr_v = '0;
      if (post_hit) set_v[post_req.idx[IDX_W-1:0]] = 1'b1;
      if (clr_hit)  clr_v[clr_req.idx[IDX_W-1:0]]  = 1'b1;
      // the set is applied after the clear, so a colliding post survives
      mask_d = clr_all ? '0 : ((mask_q & ~clr_v) | set_v);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q     <= '0;
        lvl_stat_q <= 1'b0;
      end else begin
        mask_q     <= mask_d;
        lvl_stat_q <= |mask_d;
      end
    end

    assign status_q[g] = lvl_stat_q;

    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $fell(lvl_stat_q) |-> $past(clr_all || clr_hit)); // R2
  end

  AST_POST_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> status_q[$past(post_req.lvl[LVL_W-1:0])]); // R1
  AST_CLR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (status_q == '0)); // R3
  AST_BAD_REQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    (post_req.vld && post_req.lvl[LVL_W]) |=> req_err_q); // R5
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_res_pkg::*;
#(
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = NUM_LEVELS
) (
  input  logic [NUM_LEVELS-1:0] status,
  input  logic [NUM_LEVELS-1:0] sw_req,
  output logic [LVL_W-1:0]      cand,
  output logic [NUM_LEVELS-1:0] summary
);
  always_comb begin
    cand    = '0;
    summary = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req[i]) begin
        cand       = LVL_W'(i - SW_MIN + 1);
        summary[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (status[i]) begin
        cand       = LVL_W'(i);
        summary[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = NUM_LEVELS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_vld,
  input  logic [LVL_W:0]        post_lvl,
  input  logic [IDX_W:0]        post_idx,
  input  logic                  clr_vld,
  input  logic [LVL_W:0]        clr_lvl,
  input  logic [IDX_W:0]        clr_idx,
  input  logic                  clr_all,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [LVL_W-1:0]      cur_ipl,
  input  logic [1:0]            pc_lo,
  input  logic [AST_W-1:0]      ast_req,
  input  logic                  upd_strobe,
  output logic                  irq_pending,
  output logic                  irq_take,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic [LVL_W-1:0]      int_id,
  output logic                  req_err,
  output logic                  trap_err
);
  src_req_t              post_req, clr_req;
  logic [NUM_LEVELS-1:0] status, summary;
  logic [LVL_W-1:0]      cand;

  assign post_req = '{vld: post_vld, lvl: post_lvl, idx: post_idx};
  assign clr_req  = '{vld: clr_vld,  lvl: clr_lvl,  idx: clr_idx};

  irq_pend_store u_store (
    .clk      (clk),
    .rst      (rst),
    .post_req (post_req),
    .clr_req  (clr_req),
    .clr_all  (clr_all),
    .status_q (status),
    .req_err_q(req_err)
  );

  irq_prio_sel #(
    .SW_MIN (SW_MIN),
    .SW_MAX (SW_MAX),
    .EXT_MIN(EXT_MIN),
    .EXT_MAX(EXT_MAX)
  ) u_sel (
    .status (status),
    .sw_req (sw_req),
    .cand   (cand),
    .summary(summary)
  );

  assign irq_pending = (status != '0) && (pc_lo == 2'b00);
  assign irq_take    = irq_pending && (cand != '0) && (cand > cur_ipl) && (ast_req == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_out  <= '0;
      int_id   <= '0;
      trap_err <= 1'b0;
    end else begin
      trap_err <= |ast_req;
      if (upd_strobe && irq_take) begin
        isr_out <= summary;
        int_id  <= cand;
      end
    end
  end

  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !(upd_strobe && irq_take) |=> ($stable(isr_out) && $stable(int_id))); // R10
  AST_ID_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && irq_take) |=> (int_id > $past(cur_ipl))); // R9
  AST_TRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ast_req != '0) |=> trap_err); // R11
  AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (irq_pending && pc_lo == 2'b00)); // R6
endmodule

// File: tb/irq_level_resolver_tb.sv
`timescale 1ns/1ps
module irq_level_resolver_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        post_vld, clr_vld, clr_all, upd_strobe;
  logic [5:0]  post_lvl, clr_lvl;
  logic [6:0]  post_idx, clr_idx;
  logic [31:0] sw_req;
  logic [4:0]  cur_ipl;
  logic [1:0]  pc_lo;
  logic [3:0]  ast_req;
  logic        irq_pending, irq_take, req_err, trap_err;
  logic [31:0] isr_out;
  logic [4:0]  int_id;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_level_resolver u_dut (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
    .clr_all(clr_all), .sw_req(sw_req), .cur_ipl(cur_ipl), .pc_lo(pc_lo),
    .ast_req(ast_req), .upd_strobe(upd_strobe),
    .irq_pending(irq_pending), .irq_take(irq_take), .isr_out(isr_out),
    .int_id(int_id), .req_err(req_err), .trap_err(trap_err)
  );

  typedef struct packed {
    logic [31:0] sw;
    logic [4:0]  ipl;
    logic [1:0]  pc;
    logic [3:0]  ast;
    logic        take;
    logic [31:0] isr;
    logic [4:0]  id;
  } vec_t;

  // Pending state during the table: one source at level 3 only.
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 5'd0,  2'd0, 4'h0, 1'b0, 32'h0000_0000, 5'd0 },
    '{32'h0000_0004, 5'd0,  2'd0, 4'h0, 1'b1, 32'h0000_0004, 5'd2 },
    '{32'h0000_8002, 5'd0,  2'd0, 4'h0, 1'b1, 32'h0000_8002, 5'd15},
    '{32'h0000_8002, 5'd15, 2'd0, 4'h0, 1'b0, 32'h0000_8002, 5'd15},
    '{32'h0000_0020, 5'd14, 2'd0, 4'h0, 1'b0, 32'h0000_8002, 5'd15},
    '{32'h0001_0001, 5'd0,  2'd0, 4'h0, 1'b0, 32'h0000_8002, 5'd15},
    '{32'h0000_0010, 5'd0,  2'd2, 4'h0, 1'b0, 32'h0000_8002, 5'd15},
    '{32'h0000_0010, 5'd0,  2'd1, 4'h0, 1'b0, 32'h0000_8002, 5'd15},
    '{32'h0000_0010, 5'd0,  2'd0, 4'h8, 1'b0, 32'h0000_8002, 5'd15},
    '{32'h0000_0010, 5'd0,  2'd0, 4'h0, 1'b1, 32'h0000_0010, 5'd4 },
    '{32'h0000_4000, 5'd13, 2'd0, 4'h0, 1'b1, 32'h0000_4000, 5'd14}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_req();
    post_vld = 1'b0; post_lvl = '0; post_idx = '0;
    clr_vld  = 1'b0; clr_lvl  = '0; clr_idx  = '0;
    clr_all  = 1'b0;
  endtask

  task automatic req(input logic pv, input logic [5:0] pl, input logic [6:0] pi,
                     input logic cv, input logic [5:0] cl, input logic [6:0] ci,
                     input logic ca);
    post_vld = pv; post_lvl = pl; post_idx = pi;
    clr_vld  = cv; clr_lvl  = cl; clr_idx  = ci;
    clr_all  = ca;
    tick();
    idle_req();
    #0.5;
  endtask

  task automatic strobe_once();
    upd_strobe = 1'b1;
    tick();
    upd_strobe = 1'b0;
    #0.5;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle_req();
    sw_req = '0; cur_ipl = '0; pc_lo = '0; ast_req = '0; upd_strobe = 1'b0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    #0.5;
    // reset state
    chk("R10", "reset isr_out", isr_out, 0);
    chk("R10", "reset int_id", int_id, 0);
    chk("R6", "reset irq_pending", irq_pending, 0);
    chk("R5", "reset req_err", req_err, 0);

    // R1: post level 3 index 9 (low level, pending only)
    req(1, 6'd3, 7'd9, 0, 0, 0, 0);
    chk("R1", "pending after post", irq_pending, 1);

    // vector table over the level-3 state
    for (int v = 0; v < NV; v++) begin
      sw_req = VEC[v].sw; cur_ipl = VEC[v].ipl; pc_lo = VEC[v].pc; ast_req = VEC[v].ast;
      #0.5;
      chk("R9", $sformatf("vec %0d irq_take", v), irq_take, VEC[v].take);
      chk("R6", $sformatf("vec %0d irq_pending", v), irq_pending, VEC[v].pc == 2'd0);
      strobe_once();
      chk("R7", $sformatf("vec %0d isr_out", v), isr_out, VEC[v].isr);
      chk("R10", $sformatf("vec %0d int_id", v), int_id, VEC[v].id);
      chk("R11", $sformatf("vec %0d trap_err", v), trap_err, VEC[v].ast != 4'h0);
    end
    ast_req = '0; pc_lo = '0; cur_ipl = '0; sw_req = 32'h0000_0010;

    // R8: external level overrides software
    req(1, 6'd20, 7'd63, 0, 0, 0, 0);
    strobe_once();
    chk("R8", "isr with level 20", isr_out, 32'h0010_0010);
    chk("R8", "id with level 20", int_id, 20);
    req(1, 6'd31, 7'd0, 0, 0, 0, 0);
    cur_ipl = 5'd30;
    strobe_once();
    chk("R8", "id with level 31", int_id, 31);
    chk("R8", "isr with level 31", isr_out, 32'h8010_0010);
    cur_ipl = 5'd31; #0.5;
    chk("R9", "no take at ipl 31", irq_take, 0);
    cur_ipl = 5'd0;
    req(0, 0, 0, 1, 6'd31, 7'd0, 0);
    strobe_once();
    chk("R2", "id after clearing level 31", int_id, 20);

    // R3: clear-all wins over same-cycle post
    req(1, 6'd21, 7'd1, 0, 0, 0, 1);
    chk("R3", "pending after clear-all", irq_pending, 0);
    sw_req = '0;

    // R5: out-of-range level and index
    req(1, 6'd40, 7'd0, 0, 0, 0, 0);
    chk("R5", "req_err after bad level", req_err, 1);
    chk("R5", "pending after bad level", irq_pending, 0);
    req(1, 6'd20, 7'd64, 0, 0, 0, 0);
    chk("R5", "req_err after bad index", req_err, 1);
    chk("R5", "pending after bad index", irq_pending, 0);
    tick(); #0.5;
    chk("R5", "req_err falls", req_err, 0);

    // R4: post and clear of the same bit
    req(1, 6'd22, 7'd7, 1, 6'd22, 7'd7, 0);
    chk("R4", "pending after collision", irq_pending, 1);
    req(0, 0, 0, 1, 6'd22, 7'd7, 0);
    chk("R4", "pending after clearing collided bit", irq_pending, 0);

    // R2: level stays pending until its last bit clears
    req(1, 6'd20, 7'd3, 0, 0, 0, 0);
    req(1, 6'd20, 7'd5, 0, 0, 0, 0);
    req(0, 0, 0, 1, 6'd20, 7'd3, 0);
    chk("R2", "pending with one bit left", irq_pending, 1);
    chk("R2", "take with one bit left", irq_take, 1);
    req(0, 0, 0, 1, 6'd20, 7'd5, 0);
    chk("R2", "pending after last bit", irq_pending, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule